// File: doc/BRIEF.md
# SDRAM Single-Access Command Sequencer

This block carries out one single-word read or write on an SDR SDRAM for each host request. The host supplies a request strobe, a read/write flag, a bank, a row, a column and the write data. The sequencer then plays a fixed command frame on the memory command pins. The frame opens with a NOP, then activates the row, waits out the row-to-column delay with NOPs, issues the column read or write, and closes with a NOP. The clock enable is raised only while a frame is in progress.

Write data is driven on the data pins for the column-write cycle alone. For a read, the data pins are sampled a CAS-latency count of cycles after the read command. The sampled word comes back with a one-cycle done pulse. The row-to-column gap defaults to the whole number of cycles in 20 ns at 100 MHz, which is 2. Both the gap and the CAS latency are parameters. The bidirectional data bus is split into output, output-enable and input ports, so the pad buffer sits outside this block.

Top module: `sdram_single_seq`

## Requirements
- R1: While rstN is low, memCke is 0, the command pins show NOP ({memCsN,memRasN,memCasN,memWeN} = 4'b0111), memDqOe is 0, busy is 0 and rspDone is 0.
- R2: While no transaction is in progress, memCke is 0 and the command pins show NOP (4'b0111).
- R3: A request is accepted on the rising edge at which reqValid is 1 and busy is 0. Counting that edge's following cycle as cycle 1, in cycle 1 memCke is 1, memBank equals the requested bank, and the command is NOP.
- R4: In cycle 2 the command is ACT (4'b0011) and memAddr holds the requested row.
- R5: Cycles 3 to 2+ACT_GAP show NOP (ACT_GAP defaults to 2). In cycle 3+ACT_GAP the command is RD (4'b0101) for a read or WR (4'b0100) for a write, and memAddr holds the requested column.
- R6: For a write, memDqOe is 1 and memDqOut equals the write data in the WR cycle only. memDqOe is 0 in every other cycle.
- R7: Cycle 4+ACT_GAP shows NOP. For a write, cycle 5+ACT_GAP is the done cycle, and in it memCke is 0.
- R8: For a read, memDqIn is sampled during the cycle CAS_LAT cycles after the RD cycle. Done and the sampled word appear in the next cycle, with memCke held at 1 until then and 0 in the done cycle.
- R9: busy is 1 from cycle 1 up to the cycle before done and 0 in the done cycle. A reqValid asserted while busy starts no transaction.
- R10: rspDone is a single-cycle pulse, one per accepted request.
- R11: Bank, row, column, write data and direction are taken at acceptance. Changing the request inputs later in the frame does not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | 2 | Bank of the access |
| reqRow | input | 12 | Row address |
| reqCol | input | 12 | Column address |
| reqWdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| rspDone | output | 1 | One-cycle completion pulse |
| rspData | output | 16 | Read data, valid with rspDone on a read |
| memCke | output | 1 | Memory clock enable |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write strobe, active low |
| memBank | output | 2 | Bank select |
| memAddr | output | 12 | Multiplexed row/column address |
| memDqOut | output | 16 | Data to drive on DQ |
| memDqOe | output | 1 | DQ output enable |
| memDqIn | input | 16 | Data read from DQ |

## Verification
Every memory-side output is registered, so the bench counts cycles from the accepting edge. It expects the opening NOP in cycle 1, ACT in cycle 2, the column command in cycle 3+ACT_GAP and the trailing NOP one cycle after that. Done is due in cycle 5+ACT_GAP for a write and in cycle 4+ACT_GAP+CAS_LAT for a read. All outputs are sampled on the falling edge inside each numbered cycle. memDqIn carries the read word only in the cycle CAS_LAT after the RD cycle and the inverted word in every other cycle, so a sample taken one cycle early or late returns the wrong data. While busy, the bench keeps reqValid high with scrambled fields. It then checks that the bus is idle in the cycle after done and that the frame's bank, address and data never changed.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } memCmd_e;

  // strobes from control to datapath; all describe the next cycle
  typedef struct packed {
    logic    loadReq;
    logic    ckeNext;
    memCmd_e cmdNext;
    logic    useCol;
    logic    driveDq;
    logic    capture;
    logic    doneNext;
  } seqStrobe_t;

endpackage

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int ACT_GAP = 2,
  parameter int CAS_LAT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       busy,
  output seqStrobe_t strb
);

  localparam int CNT_MAX = (ACT_GAP > CAS_LAT) ? ACT_GAP : CAS_LAT;
  localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_OPEN, S_ACTV, S_GAP, S_CMD, S_TAIL, S_RDWAIT
  } seqState_e;

  seqState_e        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             isRd, isRdNext;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    isRdNext  = isRd;
    unique case (state)
      S_IDLE: if (reqValid) begin
        stateNext = S_OPEN;
        isRdNext  = !reqWrite;
      end
      S_OPEN: stateNext = S_ACTV;
      S_ACTV: begin
        if (ACT_GAP > 0) begin
          stateNext = S_GAP;
          cntNext   = CNT_W'(ACT_GAP - 1);
        end else begin
          stateNext = S_CMD;
        end
      end
      S_GAP: begin
        if (cnt == '0) stateNext = S_CMD;
        else           cntNext   = cnt - 1'b1;
      end
      S_CMD: stateNext = S_TAIL;
      S_TAIL: begin
        if (!isRd || CAS_LAT <= 1) begin
          stateNext = S_IDLE;
        end else begin
          stateNext = S_RDWAIT;
          cntNext   = CNT_W'(CAS_LAT - 2);
        end
      end
      S_RDWAIT: begin
        if (cnt == '0) stateNext = S_IDLE;
        else           cntNext   = cnt - 1'b1;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      isRd  <= 1'b0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      isRd  <= isRdNext;
    end
  end

  logic finishing;
  assign finishing = (state != S_IDLE) && (stateNext == S_IDLE);

  always_comb begin
    strb.loadReq  = (state == S_IDLE) && reqValid;
    strb.ckeNext  = (stateNext != S_IDLE);
    strb.useCol   = (stateNext == S_CMD);
    strb.driveDq  = (stateNext == S_CMD) && !isRdNext;
    strb.capture  = finishing && isRd;
    strb.doneNext = finishing;
    unique case (stateNext)
      S_ACTV:  strb.cmdNext = CMD_ACT;
      S_CMD:   strb.cmdNext = isRdNext ? CMD_RD : CMD_WR;
      default: strb.cmdNext = CMD_NOP;
    endcase
  end

  assign busy = (state != S_IDLE);

  // direction may not change once a frame has begun
  p_dir_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(isRd));

  // a frame always starts with the opening NOP state
  p_open_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == S_IDLE && state != S_IDLE) |-> state == S_OPEN);

endmodule

// File: rtl/sdram_seq_dpath.sv
module sdram_seq_dpath
  import sdram_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [ADDR_W-1:0] reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspData,
  output logic              memCke,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [BANK_W-1:0] memBank,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  logic [ADDR_W-1:0] rowQ, colQ;
  logic [DATA_W-1:0] wdataQ;
  logic [3:0]        cmdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ   <= '0;
      colQ   <= '0;
      wdataQ <= '0;
    end else if (strb.loadReq) begin
      rowQ   <= reqRow;
      colQ   <= reqCol;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCke   <= 1'b0;
      cmdQ     <= CMD_NOP;
      memBank  <= '0;
      memAddr  <= '0;
      memDqOut <= '0;
      memDqOe  <= 1'b0;
      rspData  <= '0;
      rspDone  <= 1'b0;
    end else begin
      memCke  <= strb.ckeNext;
      cmdQ    <= strb.cmdNext;
      memDqOe <= strb.driveDq;
      rspDone <= strb.doneNext;
      if (strb.loadReq)              memBank  <= reqBank;
      if (strb.cmdNext == CMD_ACT)   memAddr  <= rowQ;
      else if (strb.useCol)          memAddr  <= colQ;
      if (strb.driveDq)              memDqOut <= wdataQ;
      if (strb.capture)              rspData  <= memDqIn;
    end
  end

  assign {memCsN, memRasN, memCasN, memWeN} = cmdQ;

  p_oe_one_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |=> !memDqOe);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  p_cmd_needs_cke_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ != CMD_NOP) |-> memCke);

  p_cke_drop_with_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCke) |-> rspDone);

  p_bank_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memCke && $past(memCke)) |-> $stable(memBank));

endmodule

// File: rtl/sdram_single_seq.sv
module sdram_single_seq
  import sdram_seq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 12,
  parameter int BANK_W  = 2,
  parameter int CLK_MHZ = 100,
  parameter int TRCD_NS = 20,
  parameter int ACT_GAP = (TRCD_NS * CLK_MHZ) / 1000,
  parameter int CAS_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [ADDR_W-1:0] reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              busy,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspData,
  output logic              memCke,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [BANK_W-1:0] memBank,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  seqStrobe_t strb;

  sdram_seq_ctrl #(
    .ACT_GAP (ACT_GAP),
    .CAS_LAT (CAS_LAT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .busy     (busy),
    .strb     (strb)
  );

  sdram_seq_dpath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqBank  (reqBank),
    .reqRow   (reqRow),
    .reqCol   (reqCol),
    .reqWdata (reqWdata),
    .rspDone  (rspDone),
    .rspData  (rspData),
    .memCke   (memCke),
    .memCsN   (memCsN),
    .memRasN  (memRasN),
    .memCasN  (memCasN),
    .memWeN   (memWeN),
    .memBank  (memBank),
    .memAddr  (memAddr),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .memDqIn  (memDqIn)
  );

endmodule

// File: tb/sdram_single_seq_bench.sv
module sdram_single_seq_bench;

  localparam int GAP = (20 * 100) / 1000;  // cycles for 20 ns at 100 MHz
  localparam int CL  = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqBank = '0;
  logic [11:0] reqRow = '0, reqCol = '0;
  logic [15:0] reqWdata = '0, memDqIn = '0;
  logic        busy, rspDone, memCke, memCsN, memRasN, memCasN, memWeN, memDqOe;
  logic [15:0] rspData, memDqOut;
  logic [1:0]  memBank;
  logic [11:0] memAddr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sdram_single_seq u_sdram_single_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .reqWdata(reqWdata),
    .busy(busy), .rspDone(rspDone), .rspData(rspData), .memCke(memCke),
    .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memBank(memBank), .memAddr(memAddr), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] expCmd(input bit wr, input int k);
    if (k == 2) return 4'b0011;
    if (k == 3 + GAP) return wr ? 4'b0100 : 4'b0101;
    return 4'b0111;
  endfunction

  function automatic int doneCycle(input bit wr);
    return wr ? 5 + GAP : 4 + GAP + CL;
  endfunction

  function automatic string cycTag(input bit wr, input int k);
    if (k == 1) return "R3";
    if (k == 2) return "R4";
    if (k == 3 + GAP) return "R5";
    if (k == 4 + GAP) return "R7";
    if (k == doneCycle(wr)) return wr ? "R7" : "R8";
    return "R5";
  endfunction

  task automatic runTxn(input bit wr, input logic [1:0] bk, input logic [11:0] row,
                        input logic [11:0] col, input logic [15:0] wd,
                        input logic [15:0] rdWord, input bit noise);
    int dk = doneCycle(wr);
    int rk = 3 + GAP;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqBank = bk; reqRow = row;
    reqCol = col; reqWdata = wd; memDqIn = ~rdWord;
    @(posedge clk);
    for (int k = 1; k <= dk; k++) begin
      @(negedge clk);
      if (noise && k < dk) begin
        reqValid = 1'b1; reqWrite = ~wr; reqBank = ~bk;
        reqRow = ~row; reqCol = ~col; reqWdata = ~wd;
      end else begin
        reqValid = 1'b0;
      end
      memDqIn = (!wr && k == rk + CL) ? rdWord : ~rdWord;
      chk(cycTag(wr, k),
          {24'd0, memCke, memCsN, memRasN, memCasN, memWeN, memDqOe},
          {24'd0, (k < dk), expCmd(wr, k), (wr && k == rk)});
      chk("R9 busy", {31'd0, busy}, {31'd0, (k < dk)});
      chk("R10 done", {31'd0, rspDone}, {31'd0, (k == dk)});
      if (k < dk) chk("R11 bank", {30'd0, memBank}, {30'd0, bk});
      if (k == 2) chk("R4 row", {20'd0, memAddr}, {20'd0, row});
      if (k == rk) chk("R5 col", {20'd0, memAddr}, {20'd0, col});
      if (wr && k == rk) chk("R6 wdata", {16'd0, memDqOut}, {16'd0, wd});
      if (!wr && k == dk) chk("R8 rdata", {16'd0, rspData}, {16'd0, rdWord});
    end
    @(negedge clk);
    chk("R2 idle after done",
        {27'd0, memCke, memCsN, memRasN, memCasN, memWeN},
        {27'd0, 1'b0, 4'b0111});
    chk("R9 no restart", {30'd0, busy, rspDone}, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5d1a_0c3e));
    repeat (3) @(negedge clk);
    chk("R1 reset", {25'd0, memCke, memCsN, memRasN, memCasN, memWeN, memDqOe, busy},
        {25'd0, 1'b0, 4'b0111, 1'b0, 1'b0});
    chk("R1 reset done", {31'd0, rspDone}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 idle", {27'd0, memCke, memCsN, memRasN, memCasN, memWeN},
        {27'd0, 1'b0, 4'b0111});

    // directed corners
    runTxn(1'b1, 2'd3, 12'hfff, 12'h000, 16'hffff, 16'h0000, 1'b0);
    runTxn(1'b0, 2'd0, 12'h000, 12'hfff, 16'h0000, 16'hffff, 1'b0);
    runTxn(1'b1, 2'd1, 12'h5a5, 12'ha5a, 16'h1234, 16'h0000, 1'b1);  // R11 noise
    runTxn(1'b0, 2'd2, 12'h3c3, 12'h0f0, 16'h0000, 16'hbeef, 1'b1);  // R9 noise

    for (int i = 0; i < 30; i++) begin
      logic [31:0] r0 = $urandom;
      logic [31:0] r1 = $urandom;
      logic [31:0] r2 = $urandom;
      runTxn(r0[0], r0[2:1], r1[11:0], r1[27:16], r2[15:0], r2[31:16], r0[3]);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule